// File: doc/BRIEF.md
# Prioritized Interrupt Vector Selector

This block sits between a small microcontroller's peripherals and its CPU core. It keeps a pending flag for each of six interrupt sources: a real-time tick, an external pin, a port wake-up input, two timers and a serial interface. At an instruction boundary it picks one winner and presents a single request, a 16-bit vector address and a source code to the CPU. The tick, pin and wake-up sources share one request and one vector. Their separate flags stay readable, so a handler can tell which of them fired.

A global inhibit bit blocks every hardware source. A software-interrupt strobe is taken whatever the inhibit bit holds. The block also owns the inhibit bit: reset sets it, acknowledging a hardware interrupt sets it, and the CPU sets or clears it through two strobes. Out of reset the block presents the reset vector through the same request and acknowledge handshake. A control register write can mask the external pin out of the shared request. Flags are cleared only by an explicit write-one-to-clear.

Top module: `irq_vector_sel`

## Requirements
- R1: While reset is asserted and until the first acknowledge, `irq_req` is 1, `irq_src` is 1 (reset) and `irq_vec` is 16'hFFFE. `inhibit` is 1, and `pend_flags` is 0.
- R2: Pending flag bits are: bit0 real-time tick, bit1 external pin, bit2 wake-up, bit3 timer A, bit4 timer B, bit5 serial. Any of bits 0 to 2 pending alone gives a take with `irq_src` 3 and vector 16'hFFFA.
- R3: Fixed priority applies: shared group (code 3, 16'hFFFA) over timer A (code 4, 16'hFFF8), over timer B (code 5, 16'hFFF6), over serial (code 6, 16'hFFF4). The external pin beats timer A.
- R4: A write with `ctl_addr` = 8'h0E stores `ctl_wdata` bit 1 as the pin mask. While the mask is 1, flag bit1 alone raises no request but still reads 1 in `pend_flags`. Writes to other addresses leave the mask unchanged.
- R5: While `inhibit` is 1, no hardware source is taken. `swi` high with `boundary` is taken whatever `inhibit` holds, with code 2 and vector 16'hFFFC, and it beats every pending hardware source.
- R6: A new take happens only on a cycle where `boundary` is 1 and no request is outstanding. `irq_src` and `irq_vec` stay stable while `irq_req` is high, until `ack`.
- R7: `ack` while `irq_req` is 1 drops `irq_req` on the next cycle. Acknowledging a hardware source (codes 3 to 6) sets `inhibit`. Acknowledging reset or software interrupt leaves it unchanged.
- R8: A pulse on `src_set` sets the matching flag, which holds until `clr_en` is 1 with that bit set in `clr_mask`. `ack` never clears a flag. A set in the same cycle as a clear leaves the flag at 1.
- R9: `inh_clr` drives `inhibit` to 0 and `inh_set` drives it to 1 on the next cycle, unless a hardware acknowledge in that cycle sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 6 | One-cycle set pulses from the six sources |
| clr_en | input | 1 | Write-one-to-clear strobe for the flags |
| clr_mask | input | 6 | Flags to clear when `clr_en` is 1 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | 8 | Control register write address |
| ctl_wdata | input | 8 | Control register write data |
| boundary | input | 1 | Instruction-boundary strobe |
| swi | input | 1 | Software-interrupt strobe, sampled with `boundary` |
| ack | input | 1 | CPU acknowledge of the presented request |
| inh_set | input | 1 | CPU sets the inhibit bit |
| inh_clr | input | 1 | CPU clears the inhibit bit |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | 16 | Vector address of the held winner |
| irq_src | output | 3 | Held winner: 1 reset, 2 software, 3 shared, 4 timer A, 5 timer B, 6 serial |
| inhibit | output | 1 | Global inhibit bit |
| pend_flags | output | 6 | Pending flags, readable by the handler |

## Verification
The bench builds the block with its default parameters: a 16-bit vector ending at 16'hFFFE, control address 8'h0E and mask bit 1. With these values every vector in the requirements is reachable and can be compared as a literal. One control write exercises the mask, and a write to a neighbouring address must leave it alone. A scoreboard holds each expected source and vector, and every rising request is compared against it. This covers the reset take, software interrupts under inhibit, each step of the priority ladder and a boundary strobe while a request is held.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int NSRC = 6;
  localparam int B_RTI = 0;
  localparam int B_PIN = 1;
  localparam int B_WAKE = 2;
  localparam int B_TMA = 3;
  localparam int B_TMB = 4;
  localparam int B_SER = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RST  = 3'd1,
    SRC_SWI  = 3'd2,
    SRC_GRP  = 3'd3,
    SRC_TMA  = 3'd4,
    SRC_TMB  = 3'd5,
    SRC_SER  = 3'd6
  } src_e;

  function automatic logic is_hw(input src_e s);
    return (s == SRC_GRP) || (s == SRC_TMA) || (s == SRC_TMB) || (s == SRC_SER);
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      pend_d[i] = pend_q[i];
      if (clr_en_i && clr_mask_i[i]) pend_d[i] = 1'b0;
      if (set_i[i]) pend_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R8: with no set and no clear, flags hold
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en_i && set_i == '0) |=> $stable(pend_q));

  // R8: every set pulse is visible on the next cycle
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0E,
  parameter int                MASK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pin_mask_o
);
  logic hit;
  logic mask_q;
  logic mask_d;

  assign hit = wr_i && (addr_i == CTL_ADDR);

  always_comb begin
    mask_d = mask_q;
    if (hit) mask_d = wdata_i[MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else        mask_q <= mask_d;
  end

  assign pin_mask_o = mask_q;

  // R4: the mask moves only on a write to its own address
  p_mask_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mask_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irqsel_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic            pin_mask_i,
  input  logic            inhibit_i,
  input  logic            swi_i,
  output src_e            win_o
);
  logic grp;

  assign grp = pend_i[B_RTI] | pend_i[B_WAKE] | (pend_i[B_PIN] & ~pin_mask_i);

  always_comb begin
    win_o = SRC_NONE;
    if (swi_i)               win_o = SRC_SWI;
    else if (inhibit_i)      win_o = SRC_NONE;
    else if (grp)            win_o = SRC_GRP;
    else if (pend_i[B_TMA])  win_o = SRC_TMA;
    else if (pend_i[B_TMB])  win_o = SRC_TMB;
    else if (pend_i[B_SER])  win_o = SRC_SER;
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold
  import irqsel_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  src_e             win_i,
  input  logic             ack_i,
  input  logic             inh_set_i,
  input  logic             inh_clr_i,
  output logic             req_o,
  output src_e             src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             inhibit_o
);
  logic req_q, req_d;
  src_e src_q, src_d;
  logic inh_q, inh_d;
  logic hw_ack;

  function automatic logic [VEC_W-1:0] vec_of(input src_e s);
    return VEC_TOP + VEC_W'(2) - VEC_W'({s, 1'b0});
  endfunction

  assign hw_ack = req_q && ack_i && is_hw(src_q);

  always_comb begin
    req_d = req_q;
    src_d = src_q;
    inh_d = inh_q;
    if (req_q) begin
      if (ack_i) req_d = 1'b0;
    end else if (boundary_i && (win_i != SRC_NONE)) begin
      req_d = 1'b1;
      src_d = win_i;
    end
    if (hw_ack)         inh_d = 1'b1;
    else if (inh_clr_i) inh_d = 1'b0;
    else if (inh_set_i) inh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b1;
      src_q <= SRC_RST;
      inh_q <= 1'b1;
    end else begin
      req_q <= req_d;
      src_q <= src_d;
      inh_q <= inh_d;
    end
  end

  assign req_o     = req_q;
  assign src_o     = src_q;
  assign vec_o     = vec_of(src_q);
  assign inhibit_o = inh_q;

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> (req_q && $stable(src_q)));

  p_no_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !boundary_i) |=> !req_q);

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack_i) |=> !req_q);

  p_hw_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack_i && is_hw(src_q)) |=> inh_q);
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
  import irqsel_pkg::*;
#(
  parameter int                VEC_W    = 16,
  parameter logic [VEC_W-1:0]  VEC_TOP  = 16'hFFFE,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0E,
  parameter int                MASK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        src_set,
  input  logic              clr_en,
  input  logic [5:0]        clr_mask,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              boundary,
  input  logic              swi,
  input  logic              ack,
  input  logic              inh_set,
  input  logic              inh_clr,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [2:0]        irq_src,
  output logic              inhibit,
  output logic [5:0]        pend_flags
);
  logic [NSRC-1:0] pend;
  logic            pin_mask;
  src_e            win;
  src_e            held;

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_en_i(clr_en),
    .clr_mask_i(clr_mask), .pend_o(pend)
  );

  irq_ctl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR), .MASK_BIT(MASK_BIT)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .addr_i(ctl_addr),
    .wdata_i(ctl_wdata), .pin_mask_o(pin_mask)
  );

  irq_arbiter u_arb (
    .pend_i(pend), .pin_mask_i(pin_mask), .inhibit_i(inhibit),
    .swi_i(swi), .win_o(win)
  );

  irq_hold #(.VEC_W(VEC_W), .VEC_TOP(VEC_TOP)) u_hold (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .win_i(win), .ack_i(ack),
    .inh_set_i(inh_set), .inh_clr_i(inh_clr), .req_o(irq_req), .src_o(held),
    .vec_o(irq_vec), .inhibit_o(inhibit)
  );

  assign irq_src    = held;
  assign pend_flags = pend;

  // R5: a newly raised request under inhibit can only be a software interrupt
  p_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (!$past(inhibit) || held == SRC_SWI));

  // R4: a shared take needs an unmasked contributor in the sampled flags
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_req) && held == SRC_GRP) |->
      ($past(pend[B_RTI]) || $past(pend[B_WAKE]) || ($past(pend[B_PIN]) && !$past(pin_mask))));
endmodule

// File: tb/irq_vector_sel_tb.sv
module irq_vector_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  src_set = '0;
  logic        clr_en = 1'b0;
  logic [5:0]  clr_mask = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_addr = '0;
  logic [7:0]  ctl_wdata = '0;
  logic        boundary = 1'b0;
  logic        swi = 1'b0;
  logic        ack = 1'b0;
  logic        inh_set = 1'b0;
  logic        inh_clr = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [2:0]  irq_src;
  logic        inhibit;
  logic [5:0]  pend_flags;

  int errors = 0;
  int checks = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];
  logic        prev_req = 1'b0;

  always #10 clk = ~clk;

  irq_vector_sel u_dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .clr_en(clr_en), .clr_mask(clr_mask),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .boundary(boundary),
    .swi(swi), .ack(ack), .inh_set(inh_set), .inh_clr(inh_clr), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_src(irq_src), .inhibit(inhibit), .pend_flags(pend_flags)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: compares every rising request against the scoreboard
  always @(negedge clk) begin
    if (irq_req && !prev_req) begin
      if (exp_q.size() == 0) begin
        chk("unexpected take", {13'd0, irq_src, irq_vec}, 32'h0);
      end else begin
        chk(tag_q.pop_front(), {13'd0, irq_src, irq_vec}, {13'd0, exp_q.pop_front()});
      end
    end
    prev_req <= irq_req;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_set(input logic [5:0] b);
    src_set = b; step(); src_set = '0;
  endtask

  task automatic w1c(input logic [5:0] b);
    clr_en = 1'b1; clr_mask = b; step(); clr_en = 1'b0; clr_mask = '0;
  endtask

  task automatic uninhibit();
    inh_clr = 1'b1; step(); inh_clr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] a, input logic [7:0] d);
    ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d; step(); ctl_wr = 1'b0;
  endtask

  task automatic do_ack(input string r);
    ack = 1'b1; step(); ack = 1'b0;
    chk(r, irq_req, 0);
  endtask

  task automatic take(input logic [2:0] s, input logic [15:0] v, input string r);
    exp_q.push_back({s, v}); tag_q.push_back(r);
    boundary = 1'b1; step(); boundary = 1'b0; swi = 1'b0;
    chk(r, irq_req, 1);
    do_ack(r);
  endtask

  task automatic no_take(input string r);
    boundary = 1'b1; step(); boundary = 1'b0; swi = 1'b0;
    chk(r, irq_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    exp_q.push_back({3'd1, 16'hFFFE}); tag_q.push_back("R1 reset vector");
    step(); step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 req", irq_req, 1);
    chk("R1 inhibit", inhibit, 1);
    chk("R1 flags", pend_flags, 0);
    do_ack("R7 reset ack");
    chk("R7 reset ack keeps inhibit", inhibit, 1);

    // R5: hardware blocked under inhibit, flag still visible (R8)
    pulse_set(6'b010000);
    no_take("R5 inhibit blocks timer B");
    chk("R8 flag held", pend_flags, 6'b010000);
    swi = 1'b1;
    take(3'd2, 16'hFFFC, "R5 swi under inhibit");
    chk("R7 swi ack keeps inhibit", inhibit, 1);

    uninhibit();
    chk("R9 inh_clr", inhibit, 0);

    // R6: hold stable across another boundary with a higher source pending
    exp_q.push_back({3'd5, 16'hFFF6}); tag_q.push_back("R3 timer B");
    boundary = 1'b1; step(); boundary = 1'b0;
    src_set = 6'b000001; step(); src_set = '0;
    boundary = 1'b1; step(); boundary = 1'b0;
    chk("R6 src held", irq_src, 5);
    chk("R6 vec held", irq_vec, 16'hFFF6);
    do_ack("R7 ack drops");
    chk("R7 hw ack sets inhibit", inhibit, 1);
    chk("R8 ack keeps flags", pend_flags, 6'b010001);
    w1c(6'b010001);
    chk("R8 w1c", pend_flags, 0);

    // R3 priority ladder
    pulse_set(6'b111000);
    uninhibit(); take(3'd4, 16'hFFF8, "R3 timer A first"); w1c(6'b001000);
    uninhibit(); take(3'd5, 16'hFFF6, "R3 timer B second"); w1c(6'b010000);
    uninhibit(); take(3'd6, 16'hFFF4, "R3 serial last"); w1c(6'b100000);

    // R3 pin beats timer A; R2 shared vector
    pulse_set(6'b001010);
    uninhibit(); take(3'd3, 16'hFFFA, "R3 pin over timer A"); w1c(6'b000010);
    uninhibit(); take(3'd4, 16'hFFF8, "R3 timer A after pin"); w1c(6'b001000);
    pulse_set(6'b000001);
    uninhibit(); take(3'd3, 16'hFFFA, "R2 tick"); w1c(6'b000001);
    pulse_set(6'b000100);
    uninhibit(); take(3'd3, 16'hFFFA, "R2 wake-up"); w1c(6'b000100);

    // R4 pin mask
    wr_ctl(8'h0E, 8'h02);
    pulse_set(6'b000010);
    uninhibit();
    no_take("R4 masked pin");
    chk("R4 masked flag readable", pend_flags, 6'b000010);
    wr_ctl(8'h0D, 8'h00);
    no_take("R4 other address ignored");
    wr_ctl(8'h0E, 8'h00);
    take(3'd3, 16'hFFFA, "R4 unmasked pin"); w1c(6'b000010);

    // R8 set wins over clear
    src_set = 6'b100000; clr_en = 1'b1; clr_mask = 6'b100000; step();
    src_set = '0; clr_en = 1'b0; clr_mask = '0;
    chk("R8 set beats clear", pend_flags, 6'b100000);
    w1c(6'b100000);

    // R6 nothing pending, and no boundary means no take
    uninhibit();
    no_take("R6 empty boundary");
    pulse_set(6'b001000);
    step();
    chk("R6 no take without boundary", irq_req, 0);

    // R5 swi beats pending hardware; R7 swi ack leaves inhibit clear
    swi = 1'b1;
    take(3'd2, 16'hFFFC, "R5 swi over timer A");
    chk("R7 swi ack leaves inhibit", inhibit, 0);
    w1c(6'b001000);

    inh_set = 1'b1; step(); inh_set = 1'b0;
    chk("R9 inh_set", inhibit, 1);

    step();
    chk("scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule